// File: doc/BRIEF.md
# Phased Test Point Activator

This block sequences a built-in self-test session through four consecutive test epochs and, in each epoch, decides which control test points are active. A session begins on a start pulse. During the session each pattern strobe counts one applied test pattern. Once the number of patterns programmed for an epoch has been counted, the block moves to the next epoch. When the last pattern of the fourth epoch has been counted, the session ends and the block reports that it is done.

A small phase decoder turns the current epoch into two enables. One gates the internal bus `sigG` through an AND-type control point that forces it to zero. The other drives the internal bus `sigH` through an OR-type control point that forces it to one. Each control point has its own parameterised set of epochs in which it forces. Outside a running session both control points are transparent. The controlled buses then feed the logic under test.

Top module: `phased_tp_activator`

## Requirements
- R1: While reset is held and just after it is released, `epoch` is 0, `done` is 0, `ctlG` equals `sigG` and `ctlH` equals `sigH`.
- R2: A `startTest` pulse seen while no session is running (idle or done) starts a session in epoch 0 and clears `done`. A `startTest` pulse seen during a running session has no effect on `epoch`.
- R3: The value of `patternsPerEpoch` is captured at start. The epoch advances on the clock edge that registers the Nth `patternStrobe` of that epoch, where N is the captured value. A captured value of 0 acts as 1. Changes to `patternsPerEpoch` during a session have no effect.
- R4: A `patternStrobe` seen while no session is running changes neither `epoch` nor `done`.
- R5: During a session in epochs 1 and 2 (default zero-force mask 4'b0110, bit e standing for epoch e), `ctlG` is all zeros.
- R6: During a session in epochs 0 and 3, `ctlG` equals `sigG`.
- R7: During a session in epochs 2 and 3 (default one-force mask 4'b1100), `ctlH` is all ones.
- R8: During a session in epochs 0 and 1, `ctlH` equals `sigH`.
- R9: After the last pattern of epoch 3, `done` goes to 1 and `epoch` stays at 3 until the next start. While done, both control points are transparent.
- R10: `epoch` is a 2-bit binary number. Within a session it only changes by stepping up by one (0 to 1 to 2 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| startTest | input | 1 | Start a test session (sampled per cycle) |
| patternsPerEpoch | input | CNT_W | Patterns to apply in each epoch |
| patternStrobe | input | 1 | One test pattern applied this cycle |
| sigG | input | G_W | Internal bus behind the force-to-zero point |
| sigH | input | H_W | Internal bus behind the force-to-one point |
| ctlG | output | G_W | Controlled version of sigG |
| ctlH | output | H_W | Controlled version of sigH |
| epoch | output | 2 | Current test epoch |
| done | output | 1 | Session complete |

## Verification
The bench checks the off-by-one at the epoch boundary: a counter that compares against N instead of N-1 would stay one strobe too long in each epoch and would miss the advance on the third strobe with a count of three. It programs a count of zero, which a naive design would treat as a wrap of the full counter range and never leave epoch 0. It changes the count in the middle of a session, and it pulses start and strobe at the wrong times; a design that does not hold its captured count, or that reacts to stray pulses, would show a moved epoch. After the session it checks that both points return to transparent while done holds epoch 3. A design that left the last epoch's forcing in place would keep `ctlH` at one.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
  localparam int EPOCH_W    = 2;
  localparam int NUM_EPOCHS = 1 << EPOCH_W;

  typedef logic [EPOCH_W-1:0] epoch_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tpaState_t;

  // strobes from the sequencer to the decode/gating path
  typedef struct packed {
    logic   testOn;
    epoch_t epoch;
  } tpaStrobes_t;
endpackage

// File: rtl/tpa_ctrl.sv
module tpa_ctrl
  import tpa_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startTest,
  input  logic [CNT_W-1:0] patternsPerEpoch,
  input  logic             patternStrobe,
  output tpaStrobes_t      strb,
  output epoch_t           epoch,
  output logic             done
);
  localparam epoch_t LAST_EPOCH = epoch_t'(NUM_EPOCHS - 1);

  tpaState_t        state;
  epoch_t           epochQ;
  logic [CNT_W-1:0] patCnt;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] lastIdxNext;
  logic             running;

  // a programmed count of zero behaves as one pattern per epoch
  always_comb begin
    if (patternsPerEpoch == '0) lastIdxNext = '0;
    else                        lastIdxNext = patternsPerEpoch - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      epochQ  <= '0;
      patCnt  <= '0;
      lastIdx <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (patternStrobe) begin
            if (patCnt == lastIdx) begin
              patCnt <= '0;
              if (epochQ == LAST_EPOCH) state  <= ST_DONE;
              else                      epochQ <= epochQ + epoch_t'(1);
            end else begin
              patCnt <= patCnt + CNT_W'(1);
            end
          end
        end
        default: begin
          if (startTest) begin
            state   <= ST_RUN;
            epochQ  <= '0;
            patCnt  <= '0;
            lastIdx <= lastIdxNext;
          end
        end
      endcase
    end
  end

  assign running     = (state == ST_RUN);
  assign done        = (state == ST_DONE);
  assign epoch       = epochQ;
  assign strb.testOn = running;
  assign strb.epoch  = epochQ;

  // R10: epoch only steps up by one, or returns to zero on a new session
  assert_epoch_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (epochQ != $past(epochQ)) |-> ((epochQ == $past(epochQ) + epoch_t'(1)) || (epochQ == '0)));

  // R2: a start during a running session leaves the epoch alone
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && startTest && !patternStrobe) |=> (running && $stable(epochQ)));

  // R4: strobes outside a session move nothing
  assert_idle_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !startTest) |=> ($stable(epochQ) && $stable(done)));

  // R9: done holds with epoch frozen at the last epoch until restarted
  assert_done_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !startTest) |=> (done && epochQ == LAST_EPOCH));
endmodule

// File: rtl/tpa_phase_dec.sv
module tpa_phase_dec
  import tpa_pkg::*;
#(
  parameter logic [NUM_EPOCHS-1:0] ZERO_MASK = 4'b0110,
  parameter logic [NUM_EPOCHS-1:0] ONE_MASK  = 4'b1100
) (
  input  tpaStrobes_t strb,
  output logic        passG,
  output logic        forceH
);
  logic [NUM_EPOCHS-1:0] epochHot;

  for (genvar e = 0; e < NUM_EPOCHS; e++) begin : g_hot
    assign epochHot[e] = strb.testOn && (strb.epoch == epoch_t'(e));
  end

  assign passG  = ~|(epochHot & ZERO_MASK);
  assign forceH =  |(epochHot & ONE_MASK);
endmodule

// File: rtl/tpa_tp_gate.sv
module tpa_tp_gate
  import tpa_pkg::*;
#(
  parameter int G_W = 1,
  parameter int H_W = 1,
  parameter logic [NUM_EPOCHS-1:0] ZERO_MASK = 4'b0110,
  parameter logic [NUM_EPOCHS-1:0] ONE_MASK  = 4'b1100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  tpaStrobes_t    strb,
  input  logic           passG,
  input  logic           forceH,
  input  logic [G_W-1:0] sigG,
  input  logic [H_W-1:0] sigH,
  output logic [G_W-1:0] ctlG,
  output logic [H_W-1:0] ctlH
);
  // AND-type point: blocks to zero; OR-type point: forces to one
  assign ctlG = sigG & {G_W{passG}};
  assign ctlH = sigH | {H_W{forceH}};

  // R5
  assert_force_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.testOn && ZERO_MASK[strb.epoch]) |-> (ctlG == '0));
  // R6, R9: transparent outside its forcing epochs
  assert_pass_g_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.testOn && ZERO_MASK[strb.epoch]) |-> (ctlG == sigG));
  // R7
  assert_force_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.testOn && ONE_MASK[strb.epoch]) |-> (ctlH == '1));
  // R8
  assert_pass_h_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.testOn && ONE_MASK[strb.epoch]) |-> (ctlH == sigH));
endmodule

// File: rtl/phased_tp_activator.sv
module phased_tp_activator
  import tpa_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int G_W   = 1,
  parameter int H_W   = 1,
  parameter logic [NUM_EPOCHS-1:0] ZERO_MASK = 4'b0110,
  parameter logic [NUM_EPOCHS-1:0] ONE_MASK  = 4'b1100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startTest,
  input  logic [CNT_W-1:0] patternsPerEpoch,
  input  logic             patternStrobe,
  input  logic [G_W-1:0]   sigG,
  input  logic [H_W-1:0]   sigH,
  output logic [G_W-1:0]   ctlG,
  output logic [H_W-1:0]   ctlH,
  output logic [1:0]       epoch,
  output logic             done
);
  tpaStrobes_t strb;
  epoch_t      epochInt;
  logic        passG;
  logic        forceH;

  tpa_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .startTest(startTest),
    .patternsPerEpoch(patternsPerEpoch), .patternStrobe(patternStrobe),
    .strb(strb), .epoch(epochInt), .done(done)
  );

  tpa_phase_dec #(.ZERO_MASK(ZERO_MASK), .ONE_MASK(ONE_MASK)) dec_i (
    .strb(strb), .passG(passG), .forceH(forceH)
  );

  tpa_tp_gate #(.G_W(G_W), .H_W(H_W), .ZERO_MASK(ZERO_MASK), .ONE_MASK(ONE_MASK)) gate_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .passG(passG), .forceH(forceH),
    .sigG(sigG), .sigH(sigH), .ctlG(ctlG), .ctlH(ctlH)
  );

  assign epoch = epochInt;
endmodule

// File: tb/phased_tp_activator_tb_top.sv
module phased_tp_activator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startTest = 1'b0;
  logic [15:0] patternsPerEpoch = 16'd1;
  logic        patternStrobe = 1'b0;
  logic [0:0]  sigG = 1'b0;
  logic [0:0]  sigH = 1'b0;
  logic [0:0]  ctlG;
  logic [0:0]  ctlH;
  logic [1:0]  epoch;
  logic        done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  phased_tp_activator dut_i (
    .clk(clk), .rst_n(rst_n), .startTest(startTest),
    .patternsPerEpoch(patternsPerEpoch), .patternStrobe(patternStrobe),
    .sigG(sigG), .sigH(sigH), .ctlG(ctlG), .ctlH(ctlH),
    .epoch(epoch), .done(done)
  );

  // {epoch, g, h, expected c1, expected c2}
  localparam logic [5:0] VEC [16] = '{
    6'b00_00_00, 6'b00_01_01, 6'b00_10_10, 6'b00_11_11,
    6'b01_00_00, 6'b01_01_01, 6'b01_10_00, 6'b01_11_01,
    6'b10_00_01, 6'b10_01_01, 6'b10_10_01, 6'b10_11_01,
    6'b11_00_01, 6'b11_01_01, 6'b11_10_11, 6'b11_11_11
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic pulseStrobe();
    @(negedge clk) patternStrobe = 1'b1;
    @(negedge clk) patternStrobe = 1'b0;
    #1;
  endtask

  task automatic pulseStart();
    @(negedge clk) startTest = 1'b1;
    @(negedge clk) startTest = 1'b0;
    #1;
  endtask

  task automatic finishSummary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finishSummary();
  end

  initial begin
    // R1: reset state
    sigG = 1'b1; sigH = 1'b0;
    #22;
    check("R1 epoch", 8'(epoch), 8'd0);
    check("R1 done", 8'(done), 8'd0);
    check("R1 c1", 8'(ctlG), 8'd1);
    check("R1 c2", 8'(ctlH), 8'd0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1 epoch after release", 8'(epoch), 8'd0);

    // R4: strobe while idle
    pulseStrobe();
    check("R4 idle strobe epoch", 8'(epoch), 8'd0);
    check("R4 idle strobe done", 8'(done), 8'd0);

    // table walk, one pattern per epoch (R5..R8, R10)
    patternsPerEpoch = 16'd1;
    pulseStart();
    check("R2 start epoch", 8'(epoch), 8'd0);
    for (int i = 0; i < 16; i++) begin
      while (epoch !== VEC[i][5:4]) pulseStrobe();
      sigG = VEC[i][3]; sigH = VEC[i][2];
      #1;
      check("R10 epoch walk", 8'(epoch), 8'(VEC[i][5:4]));
      check("R5/R6 c1", 8'(ctlG), 8'(VEC[i][1]));
      check("R7/R8 c2", 8'(ctlH), 8'(VEC[i][0]));
    end

    // R9: finish the last epoch
    pulseStrobe();
    sigG = 1'b1; sigH = 1'b0; #1;
    check("R9 done", 8'(done), 8'd1);
    check("R9 epoch frozen", 8'(epoch), 8'd3);
    check("R9 c1 transparent", 8'(ctlG), 8'd1);
    check("R9 c2 transparent", 8'(ctlH), 8'd0);
    pulseStrobe();
    check("R4 strobe in done epoch", 8'(epoch), 8'd3);
    check("R4 strobe in done", 8'(done), 8'd1);

    // R2 restart, R3 count of three
    patternsPerEpoch = 16'd3;
    pulseStart();
    check("R2 restart done cleared", 8'(done), 8'd0);
    check("R2 restart epoch", 8'(epoch), 8'd0);
    pulseStrobe(); pulseStrobe();
    check("R3 two of three", 8'(epoch), 8'd0);
    pulseStrobe();
    check("R3 third advances", 8'(epoch), 8'd1);

    // R2: start while running ignored
    pulseStart();
    check("R2 start ignored", 8'(epoch), 8'd1);

    // R3: mid-session count change ignored
    patternsPerEpoch = 16'd1;
    pulseStrobe();
    check("R3 count change ignored", 8'(epoch), 8'd1);
    pulseStrobe(); pulseStrobe();
    check("R3 captured count used", 8'(epoch), 8'd2);
    for (int k = 0; k < 20 && !done; k++) pulseStrobe();
    check("R9 done second session", 8'(done), 8'd1);

    // R3: count of zero acts as one
    patternsPerEpoch = 16'd0;
    pulseStart();
    check("R3 zero count start", 8'(epoch), 8'd0);
    pulseStrobe();
    check("R3 zero count advances", 8'(epoch), 8'd1);

    finishSummary();
  end
endmodule